// File: doc/BRIEF.md
# SEC-DED Memory Word Protection Unit

This block protects 32-bit memory words with an 8-bit check byte. On the write side it turns a data word into a 40-bit stored word: the data bits unchanged in the low 32 positions and the check byte above them. The check byte comes from a 72-by-64 single-error-correcting, double-error-detecting code with odd-weight columns. The code is defined over a 64-bit word; the upper 32 data bits are forced to zero inside the block, and all 8 check bits are still kept. The write side is purely combinational.

On the read side the 40-bit word is re-encoded and compared with the stored check byte to form the syndrome. The result is one cycle later, from registers, with a valid strobe:
- A zero syndrome means a clean word.
- A syndrome with a single bit set points at a flipped check bit. The flag is raised and the data is left alone.
- An odd-weight syndrome equal to the column of a stored data bit flips that bit back.
- Anything else is reported as uncorrectable, and the received data is passed through as it came.

An enable input turns checking off. The data then passes through raw with both flags low. Writing the corrected word back to memory is left to software.

The read stage is a two-state machine. In EMPTY, out_valid is low. In SHOW, a result is on the outputs. The transition EMPTY->SHOW (accept) and the transition SHOW->SHOW (accept again) are both taken when rd_valid is high. The transition SHOW->EMPTY (drain) is taken when rd_valid is low. EMPTY->EMPTY (idle) holds. The decode classes are CLS_CLEAN, CLS_CHKBIT, CLS_DATABIT and CLS_MULTI.

Top module: `ecc_secded_top`

## Requirements
- R1: wr_word[31:0] equals wr_data and wr_word[39:32] holds the check byte; an all-zero wr_data gives an all-zero check byte.
- R2: The check byte is linear: check(a XOR b) equals check(a) XOR check(b).
- R3: With ecc_en high, reading back an unmodified stored word returns the original data, out_syndrome zero and both flags low.
- R4: With ecc_en high and exactly one of bits 0..31 of the stored word flipped, out_data is the original data, out_corrected is 1, out_uncorrectable is 0, and out_syndrome has exactly three bits set.
- R5: With ecc_en high and exactly stored bit 32+k flipped (k in 0..7), out_data is the original data, out_corrected is 1, out_uncorrectable is 0, and out_syndrome equals 1 shifted left by k.
- R6: With ecc_en high and exactly two stored bits flipped, out_uncorrectable is 1, out_corrected is 0, and out_data equals received bits 31..0 unchanged. More generally, a nonzero syndrome that has even weight, or that matches no stored data-bit column, is flagged as uncorrectable.
- R7: With ecc_en low, out_data equals received bits 31..0, both flags are 0 and out_syndrome is 0, whatever bits were flipped.
- R8: A word presented with rd_valid high at a rising edge shows its result and out_valid high after that edge. out_valid is low after any edge at which rd_valid was low.
- R9: During and right after reset, out_valid, out_data, out_corrected, out_uncorrectable and out_syndrome are all zero.
- R10: At an edge with rd_valid low, out_data, out_syndrome and both flags keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ecc_en | input | 1 | 1 = check and correct on read, 0 = raw pass-through |
| wr_data | input | 32 | Data word to be stored |
| wr_word | output | 40 | Stored word: check byte in [39:32], data in [31:0] |
| rd_valid | input | 1 | rd_word is to be decoded at this edge |
| rd_word | input | 40 | Word read back from memory, same layout as wr_word |
| out_valid | output | 1 | Registered result present |
| out_data | output | 32 | Corrected (or raw) data |
| out_corrected | output | 1 | A single bit was corrected (data or check bit) |
| out_uncorrectable | output | 1 | Error detected that cannot be corrected |
| out_syndrome | output | 8 | Syndrome of the decoded word, zero when ecc_en is low |

## Verification
Faults inside the block surface at the ports one cycle after the read edge.
- A wrong entry in the column table shows up as a clean word reporting a nonzero syndrome, or as a single data flip left uncorrected or flagged uncorrectable.
- A wrong class choice shows up as the wrong flag for a check-bit flip or a double flip.
- A stuck read-stage state shows up as out_valid failing to follow rd_valid, or as outputs changing on idle cycles.

Every flip position class is driven through the table, and both enable settings are covered.

// File: rtl/ecc_secded_pkg.sv
`timescale 1ns/1ps
package ecc_secded_pkg;

    typedef enum logic [1:0] {
        CLS_CLEAN   = 2'd0,
        CLS_CHKBIT  = 2'd1,
        CLS_DATABIT = 2'd2,
        CLS_MULTI   = 2'd3
    } ecc_cls_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_SHOW  = 1'b1
    } rd_state_e;

    // number of set bits in a small value
    function automatic int popc(input int v);
        int n;
        n = 0;
        for (int b = 0; b < 16; b++) begin
            if (((v >> b) & 1) != 0) n++;
        end
        return n;
    endfunction

    // column idx of the data part of an odd-weight-column code:
    // all weight-3 patterns in ascending order, then weight 5, then 7, ...
    function automatic logic [15:0] hsiao_col(input int idx, input int chk_w);
        int seen;
        logic [15:0] res;
        res  = '0;
        seen = 0;
        for (int w = 3; w <= chk_w; w += 2) begin
            for (int v = 0; v < (1 << chk_w); v++) begin
                if (popc(v) == w) begin
                    if (seen == idx) res = 16'(v);
                    seen++;
                end
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/ecc_check_gen.sv
`timescale 1ns/1ps
module ecc_check_gen #(
    parameter int CODE_DW = 64,
    parameter int CHK_W   = 8
) (
    input  logic [CODE_DW-1:0] data,
    output logic [CHK_W-1:0]   chk
);
    import ecc_secded_pkg::*;

    logic [CHK_W-1:0] contrib [CODE_DW];

    for (genvar g = 0; g < CODE_DW; g++) begin : g_col
        localparam logic [15:0] COL_FULL = hsiao_col(g, CHK_W);
        assign contrib[g] = data[g] ? COL_FULL[CHK_W-1:0] : '0;
    end

    always_comb begin
        chk = '0;
        for (int i = 0; i < CODE_DW; i++) begin
            chk = chk ^ contrib[i];
        end
    end
endmodule

// File: rtl/ecc_syndrome_decode.sv
`timescale 1ns/1ps
module ecc_syndrome_decode #(
    parameter int DATA_W = 32,
    parameter int CHK_W  = 8
) (
    input  logic              en,
    input  logic [DATA_W-1:0] raw_data,
    input  logic [CHK_W-1:0]  stored_chk,
    input  logic [CHK_W-1:0]  calc_chk,
    output logic [DATA_W-1:0] fixed_data,
    output logic              corrected,
    output logic              uncorrectable,
    output logic [CHK_W-1:0]  syndrome
);
    import ecc_secded_pkg::*;

    localparam logic [CHK_W-1:0] ONE = {{(CHK_W-1){1'b0}}, 1'b1};

    logic [CHK_W-1:0]  syn;
    logic [DATA_W-1:0] hit;
    ecc_cls_e          cls;

    assign syn = calc_chk ^ stored_chk;

    // only columns of stored data bits can be corrected
    for (genvar g = 0; g < DATA_W; g++) begin : g_match
        localparam logic [15:0] COL_FULL = hsiao_col(g, CHK_W);
        assign hit[g] = (syn == COL_FULL[CHK_W-1:0]);
    end

    always_comb begin
        if (!en || syn == '0)                cls = CLS_CLEAN;
        else if ((syn & (syn - ONE)) == '0)  cls = CLS_CHKBIT;
        else if (!(^syn))                    cls = CLS_MULTI;
        else if (|hit)                       cls = CLS_DATABIT;
        else                                 cls = CLS_MULTI;
    end

    always_comb begin
        fixed_data    = raw_data;
        corrected     = 1'b0;
        uncorrectable = 1'b0;
        unique case (cls)
            CLS_CLEAN: begin
            end
            CLS_CHKBIT: begin
                corrected = 1'b1;
            end
            CLS_DATABIT: begin
                fixed_data = raw_data ^ hit;
                corrected  = 1'b1;
            end
            CLS_MULTI: begin
                uncorrectable = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign syndrome = en ? syn : '0;
endmodule

// File: rtl/ecc_read_stage.sv
`timescale 1ns/1ps
module ecc_read_stage #(
    parameter int DATA_W = 32,
    parameter int CHK_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_corr,
    input  logic              in_uncorr,
    input  logic [CHK_W-1:0]  in_syn,
    output logic              q_valid,
    output logic [DATA_W-1:0] q_data,
    output logic              q_corr,
    output logic              q_uncorr,
    output logic [CHK_W-1:0]  q_syn
);
    import ecc_secded_pkg::*;

    rd_state_e state, state_nx;

    always_comb begin
        unique case (state)
            ST_EMPTY: state_nx = take ? ST_SHOW : ST_EMPTY;
            ST_SHOW:  state_nx = take ? ST_SHOW : ST_EMPTY;
            default:  state_nx = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_data   <= '0;
            q_corr   <= 1'b0;
            q_uncorr <= 1'b0;
            q_syn    <= '0;
        end else if (take) begin
            q_data   <= in_data;
            q_corr   <= in_corr;
            q_uncorr <= in_uncorr;
            q_syn    <= in_syn;
        end
    end

    assign q_valid = (state == ST_SHOW);
endmodule

// File: rtl/ecc_secded_top.sv
`timescale 1ns/1ps
module ecc_secded_top #(
    parameter int DATA_W  = 32,
    parameter int CODE_DW = 64,
    parameter int CHK_W   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ecc_en,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [DATA_W+CHK_W-1:0] wr_word,
    input  logic                    rd_valid,
    input  logic [DATA_W+CHK_W-1:0] rd_word,
    output logic                    out_valid,
    output logic [DATA_W-1:0]       out_data,
    output logic                    out_corrected,
    output logic                    out_uncorrectable,
    output logic [CHK_W-1:0]        out_syndrome
);
    localparam int PAD_W = CODE_DW - DATA_W;

    logic [CHK_W-1:0]  wr_chk, rd_calc;
    logic [DATA_W-1:0] dec_data;
    logic              dec_corr, dec_uncorr;
    logic [CHK_W-1:0]  dec_syn;

    ecc_check_gen #(.CODE_DW(CODE_DW), .CHK_W(CHK_W)) u_wr_gen (
        .data ({{PAD_W{1'b0}}, wr_data}),
        .chk  (wr_chk)
    );

    assign wr_word = {wr_chk, wr_data};

    ecc_check_gen #(.CODE_DW(CODE_DW), .CHK_W(CHK_W)) u_rd_gen (
        .data ({{PAD_W{1'b0}}, rd_word[DATA_W-1:0]}),
        .chk  (rd_calc)
    );

    ecc_syndrome_decode #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_dec (
        .en            (ecc_en),
        .raw_data      (rd_word[DATA_W-1:0]),
        .stored_chk    (rd_word[DATA_W+:CHK_W]),
        .calc_chk      (rd_calc),
        .fixed_data    (dec_data),
        .corrected     (dec_corr),
        .uncorrectable (dec_uncorr),
        .syndrome      (dec_syn)
    );

    ecc_read_stage #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (rd_valid),
        .in_data   (dec_data),
        .in_corr   (dec_corr),
        .in_uncorr (dec_uncorr),
        .in_syn    (dec_syn),
        .q_valid   (out_valid),
        .q_data    (out_data),
        .q_corr    (out_corrected),
        .q_uncorr  (out_uncorrectable),
        .q_syn     (out_syndrome)
    );
endmodule

// File: rtl/ecc_secded_chk.sv
`timescale 1ns/1ps
module ecc_secded_chk #(
    parameter int DATA_W = 32,
    parameter int CHK_W  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    ecc_en,
    input logic [DATA_W-1:0]       wr_data,
    input logic [DATA_W+CHK_W-1:0] wr_word,
    input logic                    rd_valid,
    input logic [DATA_W+CHK_W-1:0] rd_word,
    input logic                    out_valid,
    input logic [DATA_W-1:0]       out_data,
    input logic                    out_corrected,
    input logic                    out_uncorrectable,
    input logic [CHK_W-1:0]        out_syndrome
);
    assert_wr_layout_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_word[DATA_W-1:0] == wr_data);

    assert_clean_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_syndrome == '0 |-> (!out_corrected && !out_uncorrectable));

    assert_chkbit_corr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $countones(out_syndrome) == 1) |-> out_corrected);

    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_corrected && out_uncorrectable));

    assert_uncorr_raw_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && ecc_en) |=>
            (!out_uncorrectable || out_data == $past(rd_word[DATA_W-1:0])));

    assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !ecc_en) |=>
            (out_data == $past(rd_word[DATA_W-1:0]) && !out_corrected &&
             !out_uncorrectable && out_syndrome == '0));

    assert_valid_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> out_valid);

    assert_valid_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> !out_valid);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> ($stable(out_data) && $stable(out_syndrome) &&
                       $stable(out_corrected) && $stable(out_uncorrectable)));
endmodule

bind ecc_secded_top ecc_secded_chk #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_chk (.*);

// File: tb/sim_ecc_secded_top.sv
`timescale 1ns/1ps
module sim_ecc_secded_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ecc_en = 1'b1;
    logic [31:0] wr_data = '0;
    logic [39:0] wr_word;
    logic        rd_valid = 1'b0;
    logic [39:0] rd_word = '0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_corrected, out_uncorrectable;
    logic [7:0]  out_syndrome;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ecc_secded_top u0 (
        .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .wr_data(wr_data),
        .wr_word(wr_word), .rd_valid(rd_valid), .rd_word(rd_word),
        .out_valid(out_valid), .out_data(out_data),
        .out_corrected(out_corrected), .out_uncorrectable(out_uncorrectable),
        .out_syndrome(out_syndrome)
    );

    // {data[31:0], flip_a[6:0], flip_b[6:0], en}; flip index 127 = none
    localparam int NV = 13;
    localparam logic [46:0] VEC [NV] = '{
        {32'hA5A5_3C3C, 7'd127, 7'd127, 1'b1},
        {32'h0000_0000, 7'd127, 7'd127, 1'b1},
        {32'h1234_5678, 7'd0,   7'd127, 1'b1},
        {32'hFFFF_FFFF, 7'd31,  7'd127, 1'b1},
        {32'hDEAD_BEEF, 7'd17,  7'd127, 1'b1},
        {32'h0F0F_F0F0, 7'd32,  7'd127, 1'b1},
        {32'hCAFE_0001, 7'd39,  7'd127, 1'b1},
        {32'h8000_0001, 7'd35,  7'd127, 1'b1},
        {32'h1357_9BDF, 7'd3,   7'd20,  1'b1},
        {32'h2468_ACE0, 7'd0,   7'd32,  1'b1},
        {32'h5555_AAAA, 7'd33,  7'd38,  1'b1},
        {32'h0BAD_F00D, 7'd5,   7'd127, 1'b0},
        {32'h7777_1111, 7'd9,   7'd36,  1'b0}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic encode(input logic [31:0] d, output logic [39:0] w);
        @(negedge clk);
        wr_data = d;
        #1;
        w = wr_word;
    endtask

    task automatic do_read(input logic [39:0] w, input logic en);
        @(negedge clk);
        rd_word  = w;
        ecc_en   = en;
        rd_valid = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    initial begin
        logic [39:0] code, raw, mask, ca, cb, cab;
        logic [31:0] d, keep_d;
        logic [7:0]  keep_s;
        logic [6:0]  fa, fb;
        logic        en;
        int          nf;

        repeat (3) @(negedge clk);
        // R9 reset state
        check(out_valid == 0 && out_data == 0 && out_syndrome == 0 &&
              !out_corrected && !out_uncorrectable, "R9 in reset",
              {out_valid, out_corrected, out_uncorrectable, out_syndrome, out_data}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 0 && out_data == 0 && out_syndrome == 0,
              "R9 after reset", {out_valid, out_syndrome, out_data}, 64'h0);

        // R1 layout and zero word
        encode(32'h0, code);
        check(code == 40'h0, "R1 zero word", 64'(code), 64'h0);
        encode(32'h9ABC_DEF0, code);
        check(code[31:0] == 32'h9ABC_DEF0, "R1 data field", 64'(code[31:0]), 64'h9ABC_DEF0);

        // R2 linearity
        encode(32'h1357_2468, ca);
        encode(32'h0F0F_00FF, cb);
        encode(32'h1357_2468 ^ 32'h0F0F_00FF, cab);
        check(cab[39:32] == (ca[39:32] ^ cb[39:32]), "R2 linear",
              64'(cab[39:32]), 64'(ca[39:32] ^ cb[39:32]));

        // table walk
        for (int i = 0; i < NV; i++) begin
            d  = VEC[i][46:15];
            fa = VEC[i][14:8];
            fb = VEC[i][7:1];
            en = VEC[i][0];
            encode(d, code);
            mask = '0;
            nf = 0;
            if (fa != 7'd127) begin mask[fa] = 1'b1; nf++; end
            if (fb != 7'd127) begin mask[fb] = 1'b1; nf++; end
            raw = code ^ mask;
            do_read(raw, en);
            check(out_valid == 1'b1, "R8 valid after edge", 64'(out_valid), 64'h1);
            if (!en) begin
                check(out_data == raw[31:0] && !out_corrected && !out_uncorrectable &&
                      out_syndrome == 0, "R7 bypass",
                      {out_corrected, out_uncorrectable, out_syndrome, out_data},
                      {10'h0, raw[31:0]});
            end else if (nf == 0) begin
                check(out_data == d && !out_corrected && !out_uncorrectable &&
                      out_syndrome == 0, "R3 clean read",
                      {out_corrected, out_uncorrectable, out_syndrome, out_data},
                      {10'h0, d});
            end else if (nf == 1 && fa < 7'd32) begin
                check(out_data == d && out_corrected && !out_uncorrectable &&
                      $countones(out_syndrome) == 3, "R4 data bit fix",
                      {out_corrected, out_uncorrectable, out_syndrome, out_data},
                      {2'b10, 8'h0, d});
            end else if (nf == 1) begin
                check(out_data == d && out_corrected && !out_uncorrectable &&
                      out_syndrome == (8'h1 << (fa - 7'd32)), "R5 check bit fix",
                      {out_corrected, out_uncorrectable, out_syndrome, out_data},
                      {2'b10, 8'h1 << (fa - 7'd32), d});
            end else begin
                check(out_data == raw[31:0] && !out_corrected && out_uncorrectable,
                      "R6 double flip",
                      {out_corrected, out_uncorrectable, out_syndrome, out_data},
                      {2'b01, 8'h0, raw[31:0]});
            end
        end

        // R10 hold and R8 drop on idle cycle
        keep_d = out_data;
        keep_s = out_syndrome;
        rd_word = 40'hFF_FFFF_FFFF;
        @(negedge clk);
        check(out_valid == 1'b0, "R8 valid drops", 64'(out_valid), 64'h0);
        check(out_data == keep_d && out_syndrome == keep_s, "R10 hold on idle",
              {out_syndrome, out_data}, {keep_s, keep_d});

        // R8 back-to-back words
        encode(32'h0000_00AA, ca);
        encode(32'h0000_0055, cb);
        @(negedge clk);
        ecc_en = 1'b1; rd_word = ca; rd_valid = 1'b1;
        @(negedge clk);
        check(out_valid && out_data == 32'hAA, "R8 first of pair", 64'(out_data), 64'hAA);
        rd_word = cb ^ (40'h1 << 4);
        @(negedge clk);
        rd_valid = 1'b0;
        check(out_valid && out_data == 32'h55 && out_corrected, "R8 R4 second of pair",
              64'(out_data), 64'h55);
        @(negedge clk);
        check(!out_valid, "R8 pair drains", 64'(out_valid), 64'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule